// File: doc/BRIEF.md
# Six-Pin Output Port Register Bank

This block is the configuration and routing logic for a six-pin output port. A simple 32-bit bus reaches it with an address, a write strobe, write data and combinational read data. The bank holds six registers: the output latch, a mode selection, N-channel and P-channel driver enables, a drive control word, a current-limit word and a per-pin function select. Drive strength, slew, bias and current-limit bits are stored and read back only; they affect no logic here.

Every writable register has three word addresses. The base address writes the whole register. Base+0x4 sets each bit that is written as one. Base+0x8 clears each bit that is written as one. Firmware can therefore change single pins with one store and no read-modify-write.

Each pin's output value comes from a source chosen by its function selector: the GPIO latch, a level-shift input, a timer output, a UART line, or, on the last pin only, a low-power timer toggle. A pin's output enable follows the global driver enable bit and that pin's N and P enables.

Top module: `port_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe_o` is 0 and every pin is in GPIO mode, driving the latch value 0.
- R2: A write to a base address stores the write data with reserved bits forced to zero. The latch (0x00) and the mode register (0x20) keep bits 5:0. Driver enable (0x30) keeps bits 5:0 (N) and 21:16 (P). Drive control (0x40) keeps bits 5:0, 16, 17, 19:18 and 23:21. Current limit (0x50) keeps bits 5:0 and 23:16. Function select (0x70) keeps bits 12:0. A register changes only when it is written.
- R3: A write to base+0x4 ORs the masked write data into the register.
- R4: A write to base+0x8 clears every register bit whose write-data bit is one.
- R5: Reads of alias addresses (address bits 3:2 not 00), of unmapped pages, and of addresses with bits 1:0 not 00 return zero. Writes to such addresses are ignored.
- R6: Address 0x10 reads `pad_i` in bits 5:0 and is read-only. A write there changes no register.
- R7: Pin n (n = 0..4) uses selector bits [2n+1:2n], and pin 5 uses bits 12:10. Selector 0 routes the latch bit, 1 routes `lvl_i[n]` and 2 routes `tmr_i[n]`.
- R8: Selector 3 routes `uart_i` to pins 2, 3, 4 and 5: `uart_i[0]` (TX), `uart_i[1]` (RX), `uart_i[2]` (RTS) and `uart_i[3]` (CTS).
- R9: Selector 4 on pin 5 routes `lpt_i`.
- R10: Selectors with no source fall back to the latch bit. These are 3 on pins 0 and 1, and 5 to 7 on pin 5.
- R11: `pin_oe_o[n]` is drive-control bit 22 AND (N enable bit n OR P enable bit 16+n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational from addr_i) |
| pad_i | input | 6 | Pin levels for readback |
| lvl_i | input | 6 | Level-shift source per pin |
| tmr_i | input | 6 | Timer output source per pin |
| uart_i | input | 4 | UART TX, RX, RTS, CTS for pins 2..5 |
| lpt_i | input | 1 | Low-power timer toggle for pin 5 |
| pin_o | output | 6 | Routed output value per pin |
| pin_oe_o | output | 6 | Output enable per pin |

## Verification
The bench writes all ones to each register. A wrong reserved-bit mask would show up as stray bits on readback. The set and clear aliases are checked against bit patterns that overlap the current value, so an alias wired as a plain write or as an inverted clear gives a wrong word. The function mux is driven with distinct patterns on the level-shift, timer and UART inputs, so a swapped source or a miswired UART line changes `pin_o`. The same checks cover the undefined selectors on pins 0, 1 and 5: with the latch set to ones, a missing fallback appears as a wrong bit. Output enables are checked with only N, only P and neither enabled on chosen pins, and with the global drive bit cleared.

// File: rtl/port_bank_pkg.sv
package port_bank_pkg;
  localparam int NPIN   = 6;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int NREG   = 6;
  localparam int FSEL_W = 2 * (NPIN - 1) + 3;
  localparam int P_LSB  = 16;
  localparam int OE_BIT = 22;

  localparam logic [DW-1:0] PIN_MASK  = DW'((64'd1 << NPIN) - 1);
  localparam logic [DW-1:0] FSEL_MASK = DW'((64'd1 << FSEL_W) - 1);

  localparam logic [3:0] PAGE_PIN = 4'h1;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  // register slot -> address page
  function automatic logic [3:0] reg_page(int idx);
    case (idx)
      0: return 4'h0;  // latch
      1: return 4'h2;  // mode
      2: return 4'h3;  // driver enables
      3: return 4'h4;  // drive control
      4: return 4'h5;  // current limit
      default: return 4'h7;  // function select
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_mask(int idx);
    case (idx)
      0, 1: return PIN_MASK;
      2: return PIN_MASK | (PIN_MASK << P_LSB);
      3: return PIN_MASK | DW'(32'h00EF_0000);
      4: return PIN_MASK | DW'(32'h00FF_0000);
      default: return FSEL_MASK;
    endcase
  endfunction
endpackage

// File: rtl/port_alias_reg.sv
module port_alias_reg
  import port_bank_pkg::*;
#(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  acc_e         acc_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (wr_i) begin
      case (acc_i)
        ACC_PLAIN: q_o <= wdata_i & MASK;
        ACC_SET:   q_o <= q_o | (wdata_i & MASK);
        ACC_CLR:   q_o <= q_o & ~wdata_i;
        default:   q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux #(
  parameter int SW       = 2,
  parameter bit HAS_UART = 1'b0,
  parameter bit HAS_LPT  = 1'b0
) (
  input  logic [SW-1:0] sel_i,
  input  logic          gpio_i,
  input  logic          lvl_i,
  input  logic          tmr_i,
  input  logic          uart_i,
  input  logic          lpt_i,
  output logic          out_o
);
  always_comb begin
    out_o = gpio_i;
    if (int'(sel_i) == 1)                  out_o = lvl_i;
    else if (int'(sel_i) == 2)             out_o = tmr_i;
    else if (HAS_UART && int'(sel_i) == 3) out_o = uart_i;
    else if (HAS_LPT && int'(sel_i) == 4)  out_o = lpt_i;
  end
endmodule

// File: rtl/port_bank.sv
module port_bank
  import port_bank_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NPIN-1:0] pad_i,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] tmr_i,
  input  logic [3:0]      uart_i,
  input  logic            lpt_i,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe_o
);
  logic [3:0]  page;
  acc_e        acc;
  logic        aligned;
  logic [DW-1:0] regs_q [NREG];

  assign page    = addr_i[7:4];
  assign acc     = acc_e'(addr_i[3:2]);
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    port_alias_reg #(.W(DW), .MASK(reg_mask(i))) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && aligned && (page == reg_page(i))),
      .acc_i  (acc),
      .wdata_i(wdata_i),
      .q_o    (regs_q[i])
    );
  end

  logic [NPIN-1:0]   latch_q;
  logic [DW-1:0]     den_q;
  logic [DW-1:0]     drv_q;
  logic [FSEL_W-1:0] fsel_q;

  assign latch_q = regs_q[0][NPIN-1:0];
  assign den_q   = regs_q[2];
  assign drv_q   = regs_q[3];
  assign fsel_q  = regs_q[5][FSEL_W-1:0];

  always_comb begin
    rdata_o = '0;
    if (aligned && acc == ACC_PLAIN) begin
      if (page == PAGE_PIN) rdata_o = DW'(pad_i);
      for (int i = 0; i < NREG; i++)
        if (page == reg_page(i)) rdata_o = regs_q[i];
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    localparam bit LAST = (n == NPIN - 1);
    localparam int SW   = LAST ? 3 : 2;
    localparam int UIDX = (n >= 2) ? n - 2 : 0;
    port_pin_mux #(.SW(SW), .HAS_UART(n >= 2), .HAS_LPT(LAST)) u_mux (
      .sel_i (fsel_q[2*n +: SW]),
      .gpio_i(latch_q[n]),
      .lvl_i (lvl_i[n]),
      .tmr_i (tmr_i[n]),
      .uart_i(uart_i[UIDX]),
      .lpt_i (lpt_i),
      .out_o (pin_o[n])
    );
  end

  assign pin_oe_o = {NPIN{drv_q[OE_BIT]}} & (den_q[NPIN-1:0] | den_q[P_LSB +: NPIN]);
endmodule

// File: rtl/port_bank_chk.sv
module port_bank_chk
  import port_bank_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              we_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NPIN-1:0]   latch_q,
  input logic [DW-1:0]     drv_q,
  input logic [FSEL_W-1:0] fsel_q,
  input logic [NPIN-1:0]   pin_o,
  input logic [NPIN-1:0]   pin_oe_o
);
  // R3
  set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h04) |=>
      ((latch_q & $past(wdata_i[NPIN-1:0])) == $past(wdata_i[NPIN-1:0])));

  // R4
  clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h08) |=> ((latch_q & $past(wdata_i[NPIN-1:0])) == '0));

  // R2
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i[7:4] == 4'h0) |=> $stable(latch_q));

  // R5
  alias_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:2] != 2'b00) |-> (rdata_o == '0));

  // R11
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_q[OE_BIT] |-> (pin_oe_o == '0));

  // R7
  gpio_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel_q == '0) |-> (pin_o == latch_q));
endmodule

bind port_bank port_bank_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .latch_q (latch_q),
  .drv_q   (drv_q),
  .fsel_q  (fsel_q),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o)
);

// File: tb/port_bank_bench.sv
`timescale 1ns/1ps
module port_bank_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pad = '0, lvl = '0, tmr = '0, pin, pin_oe;
  logic [3:0]  uart = '0;
  logic        lpt = 0;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    int          kind;  // 0 rdata, 1 pin_o, 2 pin_oe_o
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  port_bank u_port_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad), .lvl_i(lvl), .tmr_i(tmr), .uart_i(uart),
    .lpt_i(lpt), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? 32'(pin) : 32'(pin_oe);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic expect_item(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a;
    expect_item(0, e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    lvl = 6'h19; tmr = 6'h26; uart = 4'b1010;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    expect_item(1, 32'h0, "R1 pin_o in reset");
    rst_n = 1;
    @(negedge clk); #1;
    rd(8'h00, 32'h0, "R1 latch");
    rd(8'h30, 32'h0, "R1 den");
    rd(8'h40, 32'h0, "R1 drv");
    rd(8'h70, 32'h0, "R1 fsel");
    expect_item(2, 32'h0, "R1 oe");
    expect_item(1, 32'h0, "R1 pin_o");

    // R2 masks
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'h0000_003F, "R2 latch mask");
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 32'h0000_003F, "R2 mode mask");
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, 32'h003F_003F, "R2 den mask");
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, 32'h00EF_003F, "R2 drv mask");
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, 32'h00FF_003F, "R2 ilim mask");
    wr(8'h70, 32'hFFFF_FFFF); rd(8'h70, 32'h0000_1FFF, "R2 fsel mask");

    // R3 / R4 aliases
    wr(8'h00, 32'h05);
    wr(8'h04, 32'h30); rd(8'h00, 32'h35, "R3 set latch");
    wr(8'h08, 32'h11); rd(8'h00, 32'h24, "R4 clr latch");
    wr(8'h28, 32'h0F); rd(8'h20, 32'h30, "R4 clr mode");

    // R5
    rd(8'h04, 32'h0, "R5 set alias read");
    rd(8'h08, 32'h0, "R5 clr alias read");
    rd(8'h60, 32'h0, "R5 unmapped");
    rd(8'h02, 32'h0, "R5 unaligned");
    wr(8'h01, 32'h3F); rd(8'h00, 32'h24, "R5 unaligned write ignored");

    // R6
    pad = 6'h15;
    rd(8'h10, 32'h15, "R6 readback");
    wr(8'h10, 32'h3F);
    rd(8'h10, 32'h15, "R6 read-only");
    rd(8'h00, 32'h24, "R6 latch untouched");

    wr(8'h04, 32'h03); rd(8'h00, 32'h27, "R3 set latch low bits");

    // R7
    wr(8'h70, 32'h0);   expect_item(1, 32'h27, "R7 gpio");
    wr(8'h70, 32'h555); expect_item(1, 32'h19, "R7 level shift");
    wr(8'h70, 32'hAAA); expect_item(1, 32'h26, "R7 timer");

    // R8 / R10 (pins 0,1 fall back)
    wr(8'h70, 32'hFFF); expect_item(1, 32'h2B, "R8 R10 uart 1010");
    uart = 4'b0101;     expect_item(1, 32'h17, "R8 uart 0101");

    // R9
    lpt = 1;
    wr(8'h70, 32'h1000); expect_item(1, 32'h27, "R9 lpt high");
    lpt = 0;             expect_item(1, 32'h07, "R9 lpt low");

    // R10 pin 5
    wr(8'h70, 32'h1400); expect_item(1, 32'h27, "R10 sel5");
    wr(8'h70, 32'h1800); expect_item(1, 32'h27, "R10 sel6");
    wr(8'h70, 32'h1C00); expect_item(1, 32'h27, "R10 sel7");

    // R11
    expect_item(2, 32'h3F, "R11 all enabled");
    wr(8'h38, 32'h003F_0000); expect_item(2, 32'h3F, "R11 N only");
    wr(8'h38, 32'h0000_0005); expect_item(2, 32'h3A, "R11 some off");
    wr(8'h34, 32'h0001_0000); expect_item(2, 32'h3B, "R11 P only pin0");
    rd(8'h30, 32'h0001_003A, "R3 den set");
    wr(8'h48, 32'h0040_0000); expect_item(2, 32'h00, "R11 global off");
    rd(8'h40, 32'h00AF_003F, "R4 drv clr");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule